// File: doc/BRIEF.md
# Integer-Mode PLL Divider Calculator

This block turns a requested local-oscillator frequency, given in whole MHz, into the integer settings of a frequency synthesizer that runs from a 50 MHz reference. It picks a power-of-two output divider so that the VCO sits as high as it can below a 5400 MHz ceiling. It then chooses the feedback prescaler and the charge-pump code from where the VCO lands relative to a 3200 MHz split. Last, it derives the integer feedback count and the frequency that these settings actually produce.

A request is loaded with a single-cycle `start_i`. The block then works through a sequence of iterative steps: a restoring division of the ceiling by the request, a shift-and-count base-2 logarithm, and a second restoring division by the reference. When every result is ready it raises `done_o` for one cycle and holds the results until the next accepted request. The fractional-N fields are part of the result set and are always zero. A request outside 1..5400 is rejected with a one-cycle `err_o` and no computation.

Top module: `synth_int_calc`

## Requirements
- R1: `n_lo_o` equals floor(log2(floor(5400 / lo))), for example 3 for lo = 500, 12 for lo = 1 and 0 for lo = 5400.
- R2: `lodiv_o` equals 2 raised to `n_lo_o`, and `fvco_o` equals `lodiv_o` times the request.
- R3: When `fvco_o` is above 3200 the feedback divider `fbkdiv_o` is 4, `pump_o` is 3 and `presc_o` (feedback divider shifted right by one) is 2. Otherwise `fbkdiv_o` is 2, `pump_o` is 2 and `presc_o` is 1. A VCO of exactly 3200 takes the lower setting.
- R4: `n_o` equals (`fvco_o` / `fbkdiv_o`) / 50, with both divisions truncating.
- R5: `tune_o` equals 50 x `n_o` x `fbkdiv_o` / `lodiv_o`, truncated. It may be 0 for very low requests.
- R6: `frac_hi_o` and `frac_lo_o` are zero at all times.
- R7: A request of 0 or above 5400 raises `err_o` for exactly one cycle, one clock after the start. `done_o` and `busy_o` stay low, and every result output keeps its previous value.
- R8: After an accepted start, `busy_o` is high from the next cycle until the cycle in which `done_o` rises. `done_o` is high for exactly one cycle, and `busy_o` is low in that cycle.
- R9: A `start_i` that arrives while `busy_o` is high is ignored. The results that follow belong to the request that was already running.
- R10: After reset, `busy_o`, `done_o`, `err_o` and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Single-cycle request strobe |
| lo_mhz_i | input | 13 | Requested frequency in MHz |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle pulse, results valid |
| err_o | output | 1 | One-cycle pulse, request out of range |
| n_lo_o | output | 4 | Output divider exponent |
| lodiv_o | output | 16 | Output divider value |
| fvco_o | output | 16 | VCO frequency in MHz |
| fbkdiv_o | output | 3 | Feedback divider (2 or 4) |
| presc_o | output | 2 | Prescaler field |
| pump_o | output | 2 | Charge-pump current code |
| n_o | output | 16 | Integer feedback count |
| tune_o | output | 16 | Achieved frequency in MHz |
| frac_hi_o | output | 16 | Fractional upper field, zero |
| frac_lo_o | output | 8 | Fractional lower field, zero |

## Verification
If the logarithm counter is off by one shift, `lodiv_o` is wrong by a factor of two and `fvco_o` falls outside 2700..5400. The same fault usually flips the prescaler choice, so the next `done_o` pulse already shows it. A division that is wrong or stops early leaves `n_o` inconsistent with `fvco_o` and `fbkdiv_o`, and this shows up at that same pulse. The vectors sit on both sides of the 3200 split and of the quotient boundaries at 2700, 1600 and 5400. They also include the lowest request, where `tune_o` truncates to zero.

// File: rtl/synth_calc_pkg.sv
package synth_calc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_QDIV,
    ST_LOG,
    ST_NDIV
  } calc_state_e;
endpackage

// File: rtl/int_div_restoring.sv
module int_div_restoring #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic [W:0]    trial;
  logic          ge;
  logic [W-1:0]  diff;

  assign trial = {rem_q, quo_q[W-1]};
  assign ge    = trial[W] | (trial[W-1:0] >= dvs_q);
  // true difference is below dvs_q, so modulo-2^W subtraction is exact
  assign diff  = trial[W-1:0] - dvs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q  <= '0;
        quo_q  <= dividend_i;
        dvs_q  <= divisor_i;
        cnt_q  <= CW'(W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= ge ? diff : trial[W-1:0];
        quo_q <= {quo_q[W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q;

  // R4
  rem_below_divisor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rem_q < dvs_q));
endmodule

// File: rtl/floor_log2_iter.sv
module floor_log2_iter #(
  parameter int W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [W-1:0]  value_i,
  output logic          done_o,
  output logic [$clog2(W)-1:0] exp_o
);
  localparam int EW = $clog2(W);

  logic [W-1:0]  x_q;
  logic [EW-1:0] cnt_q;
  logic          busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        x_q    <= value_i;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (x_q > W'(1)) begin
          x_q   <= x_q >> 1;
          cnt_q <= cnt_q + 1'b1;
        end else begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign exp_o  = cnt_q;

  // R1
  shift_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !start_i && x_q > W'(1)) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/synth_int_calc.sv
module synth_int_calc
  import synth_calc_pkg::*;
#(
  parameter int LO_MAX    = 5400,
  parameter int REF_MHZ   = 50,
  parameter int VCO_SPLIT = 3200,
  parameter int FW        = 13,
  parameter int DW        = 16,
  parameter int EW        = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [FW-1:0] lo_mhz_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [EW-1:0] n_lo_o,
  output logic [DW-1:0] lodiv_o,
  output logic [DW-1:0] fvco_o,
  output logic [2:0]    fbkdiv_o,
  output logic [1:0]    presc_o,
  output logic [1:0]    pump_o,
  output logic [DW-1:0] n_o,
  output logic [DW-1:0] tune_o,
  output logic [DW-1:0] frac_hi_o,
  output logic [7:0]    frac_lo_o
);
  calc_state_e   state_q;
  logic [FW-1:0] lo_q;
  logic [EW-1:0] n_lo_q;
  logic [DW-1:0] lodiv_q, fvco_q, n_q;
  logic [2:0]    fbk_q;
  logic [1:0]    pump_q;
  logic          done_q, err_q;

  logic          req_ok;
  logic          div_start, div_done;
  logic [DW-1:0] div_dvd, div_dvs, div_quot;
  logic          log_start, log_done;
  logic [EW-1:0] log_exp;
  logic [DW-1:0] fvco_w;
  logic          hi_band;

  assign req_ok    = (lo_mhz_i != '0) && (int'(lo_mhz_i) <= LO_MAX);
  assign fvco_w    = DW'(lo_q) << log_exp;
  assign hi_band   = fvco_w > DW'(VCO_SPLIT);

  assign div_start = ((state_q == ST_IDLE) && start_i && req_ok) ||
                     ((state_q == ST_LOG) && log_done);
  assign div_dvd   = (state_q == ST_IDLE) ? DW'(LO_MAX)
                   : (hi_band ? (fvco_w >> 2) : (fvco_w >> 1));
  assign div_dvs   = (state_q == ST_IDLE) ? DW'(lo_mhz_i) : DW'(REF_MHZ);
  assign log_start = (state_q == ST_QDIV) && div_done;

  int_div_restoring #(.W(DW)) i_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_start),
    .dividend_i (div_dvd),
    .divisor_i  (div_dvs),
    .done_o     (div_done),
    .quot_o     (div_quot)
  );

  floor_log2_iter #(.W(DW)) i_log (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (log_start),
    .value_i (div_quot),
    .done_o  (log_done),
    .exp_o   (log_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lo_q    <= '0;
      n_lo_q  <= '0;
      lodiv_q <= '0;
      fvco_q  <= '0;
      fbk_q   <= '0;
      pump_q  <= '0;
      n_q     <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (req_ok) begin
            lo_q    <= lo_mhz_i;
            state_q <= ST_QDIV;
          end else begin
            err_q <= 1'b1;
          end
        end
        ST_QDIV: if (div_done) state_q <= ST_LOG;
        ST_LOG: if (log_done) begin
          n_lo_q  <= log_exp;
          lodiv_q <= DW'(1) << log_exp;
          fvco_q  <= fvco_w;
          fbk_q   <= hi_band ? 3'd4 : 3'd2;
          pump_q  <= hi_band ? 2'd3 : 2'd2;
          state_q <= ST_NDIV;
        end
        ST_NDIV: if (div_done) begin
          n_q     <= div_quot;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign n_lo_o    = n_lo_q;
  assign lodiv_o   = lodiv_q;
  assign fvco_o    = fvco_q;
  assign fbkdiv_o  = fbk_q;
  assign presc_o   = fbk_q[2:1];
  assign pump_o    = pump_q;
  assign n_o       = n_q;
  assign tune_o    = (DW'(REF_MHZ) * n_q * DW'(fbk_q)) >> n_lo_q;
  assign frac_hi_o = '0;
  assign frac_lo_o = '0;

  // R2
  fvco_product_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (fvco_o == DW'(lo_q) * lodiv_o));
  // R3
  pump_band_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((fvco_o > DW'(VCO_SPLIT)) == (pump_o == 2'd3)));
  // R4
  n_bracket_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((n_o * DW'(fbkdiv_o) * DW'(REF_MHZ) <= fvco_o) &&
                ((n_o + 1'b1) * DW'(fbkdiv_o) * DW'(REF_MHZ) > fvco_o)));
  // R7
  err_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!done_o && !busy_o && $stable(n_o) && $stable(fvco_o)));
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o ##1 !done_o));
  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(lo_q));
endmodule

// File: tb/test_synth_int_calc.sv
module test_synth_int_calc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [12:0] lo_mhz_i = '0;
  logic        busy_o, done_o, err_o;
  logic [3:0]  n_lo_o;
  logic [15:0] lodiv_o, fvco_o, n_o, tune_o, frac_hi_o;
  logic [2:0]  fbkdiv_o;
  logic [1:0]  presc_o, pump_o;
  logic [7:0]  frac_lo_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk_i = ~clk_i;

  synth_int_calc i_synth_int_calc (
    .clk_i, .rst_ni, .start_i, .lo_mhz_i, .busy_o, .done_o, .err_o,
    .n_lo_o, .lodiv_o, .fvco_o, .fbkdiv_o, .presc_o, .pump_o, .n_o,
    .tune_o, .frac_hi_o, .frac_lo_o
  );

  // lo, n_lo, fvco, fbkdiv, n, tune
  localparam int NV = 12;
  localparam int VEC [NV][6] = '{
    '{500,   3, 4000, 4, 20,  500},
    '{525,   3, 4200, 4, 21,  525},
    '{1500,  1, 3000, 2, 30, 1500},
    '{1525,  1, 3050, 2, 30, 1500},
    '{1550,  1, 3100, 2, 31, 1550},
    '{1,    12, 4096, 4, 20,    0},
    '{5400,  0, 5400, 4, 27, 5400},
    '{1600,  1, 3200, 2, 32, 1600},
    '{1601,  1, 3202, 4, 16, 1600},
    '{2700,  1, 5400, 4, 27, 2700},
    '{2701,  0, 2701, 2, 27, 2700},
    '{100,   5, 3200, 2, 32,  100}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog R8: actual %0d expected %0d", cycles, 100000);
      finish_run();
    end
  end

  task automatic pulse_start(input int lo);
    @(negedge clk_i);
    lo_mhz_i = 13'(lo);
    start_i  = 1'b1;
    @(negedge clk_i);
    start_i  = 1'b0;
  endtask

  task automatic wait_done(output int waited);
    waited = 0;
    while (!done_o && waited < 500) begin
      @(negedge clk_i);
      waited++;
    end
  endtask

  task automatic check_vec(input int v);
    chk("R1 n_lo", int'(n_lo_o), VEC[v][1]);
    chk("R2 lodiv", int'(lodiv_o), 1 << VEC[v][1]);
    chk("R2 fvco", int'(fvco_o), VEC[v][2]);
    chk("R3 fbkdiv", int'(fbkdiv_o), VEC[v][3]);
    chk("R3 pump", int'(pump_o), (VEC[v][3] == 4) ? 3 : 2);
    chk("R3 presc", int'(presc_o), VEC[v][3] >> 1);
    chk("R4 n", int'(n_o), VEC[v][4]);
    chk("R5 tune", int'(tune_o), VEC[v][5]);
    chk("R6 frac", int'(frac_hi_o) + int'(frac_lo_o), 0);
  endtask

  initial begin
    int waited;
    int prev_tune;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10 busy", int'(busy_o), 0);
    chk("R10 done", int'(done_o), 0);
    chk("R10 err", int'(err_o), 0);
    chk("R10 results", int'(n_lo_o) + int'(lodiv_o) + int'(fvco_o) + int'(fbkdiv_o)
        + int'(pump_o) + int'(n_o) + int'(tune_o), 0);
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      pulse_start(VEC[v][0]);
      chk("R8 busy after start", int'(busy_o), 1);
      wait_done(waited);
      chk("R8 done reached", int'(done_o), 1);
      chk("R8 busy low at done", int'(busy_o), 0);
      check_vec(v);
      @(negedge clk_i);
      chk("R8 done single cycle", int'(done_o), 0);
    end

    // R9: second start while busy is ignored
    pulse_start(1500);
    @(negedge clk_i);
    lo_mhz_i = 13'd500;
    start_i  = 1'b1;
    repeat (3) @(negedge clk_i);
    start_i  = 1'b0;
    wait_done(waited);
    chk("R9 done", int'(done_o), 1);
    chk("R9 first request kept", int'(tune_o), 1500);
    chk("R9 fvco", int'(fvco_o), 3000);
    repeat (60) begin
      @(negedge clk_i);
      if (done_o) chk("R9 no second done", 1, 0);
    end
    chk("R9 idle", int'(busy_o), 0);

    // R7: out of range requests
    prev_tune = int'(tune_o);
    pulse_start(0);
    chk("R7 err on zero", int'(err_o), 1);
    chk("R7 no done on zero", int'(done_o), 0);
    chk("R7 no busy on zero", int'(busy_o), 0);
    @(negedge clk_i);
    chk("R7 err single cycle", int'(err_o), 0);
    chk("R7 results kept", int'(tune_o), prev_tune);
    pulse_start(5401);
    chk("R7 err above max", int'(err_o), 1);
    chk("R7 no busy above max", int'(busy_o), 0);
    repeat (60) begin
      @(negedge clk_i);
      if (done_o) chk("R7 no done above max", 1, 0);
    end
    chk("R7 fvco kept", int'(fvco_o), 3000);
    chk("R7 n kept", int'(n_o), 30);

    // R1 R3 back to a high-band request after errors
    pulse_start(VEC[0][0]);
    wait_done(waited);
    check_vec(0);

    // R10 reset mid-computation clears everything
    pulse_start(525);
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R10 busy after reset", int'(busy_o), 0);
    chk("R10 fvco after reset", int'(fvco_o), 0);
    chk("R10 tune after reset", int'(tune_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    finish_run();
  end
endmodule